// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block runs single read and write cycles on an asynchronous static RAM, 32K x 8 by default. The RAM shares one data bus for both directions. A host hands in one request at a time on a valid/ready handshake. It supplies an address, a direction bit and, for writes, a data byte. The controller then drives the active-low chip select, write enable and output enable strobes, the address bus, and a data-bus driver with its own enable. It ends every request with a one-cycle done pulse, and on a read it returns the byte it captured.

Each cycle is built from phases counted in clock cycles, and a parameter sets the length of each phase. A write runs address setup, write-enable lead, write pulse, data hold and recovery. Write enable always falls before chip select. As a result the write is controlled by chip select, and the RAM outputs stay high-impedance for the whole write. A read runs address setup and access, then one turnaround cycle with all strobes high. The controller never drives the bus while the RAM may be driving it. In idle the RAM is deselected.

The controller is a state machine. Its states are IDLE, WR_SETUP, WR_LEAD, WR_PULSE, WR_HOLD, WR_REC, RD_SETUP, RD_ACCESS and RD_TURN. IDLE goes to WR_SETUP or RD_SETUP when a request is accepted. Every other state moves on when its phase timer expires, along these paths:
- WR_SETUP, then WR_LEAD, then WR_PULSE.
- WR_PULSE to WR_HOLD, or straight to WR_REC when the hold length is zero.
- WR_HOLD, then WR_REC, then IDLE.
- RD_SETUP, then RD_ACCESS, then RD_TURN, then IDLE.

Top module: `sram_cycle_ctl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready` is 1, the strobes are all high (`sram_cs_n`=1, `sram_we_n`=1, `sram_oe_n`=1), `sram_dq_oe` is 0 and no done pulse is pending.
- R2: A request is accepted at a clock edge where `req_valid`=1 and `req_ready`=1. `req_ready` is then 0 from the next cycle until the cycle completes. Exactly one one-cycle `rsp_done` pulse follows each accepted request, and `req_ready` is 1 in the same cycle as that pulse.
- R3: On a write (`req_write`=1), `sram_we_n` falls LEAD_CYC cycles before `sram_cs_n` falls. Both rise on the same clock edge, and `sram_oe_n` stays 1 throughout.
- R4: The accepted address is on `sram_addr` from the first busy cycle and stays unchanged until `req_ready` returns. All strobes stay high for SETUP_CYC cycles before the first strobe falls.
- R5: On a write, `sram_cs_n` and `sram_we_n` are both low for exactly PULSE_CYC consecutive cycles.
- R6: `sram_dq_out` carries the accepted write byte with `sram_dq_oe`=1 from `sram_we_n` falling until HOLD_CYC cycles after the strobes rise. `sram_dq_oe` is 0 in every other cycle.
- R7: After the data driver turns off, a write keeps all strobes high and the address unchanged for RECOV_CYC cycles before `req_ready` returns.
- R8: On a read (`req_write`=0), `sram_cs_n` and `sram_oe_n` are low with `sram_we_n`=1 for exactly ACCESS_CYC cycles. `rsp_rdata` takes the value of `sram_dq_in` from the last of these cycles and holds it from the done pulse until the next read completes.
- R9: After a read, all strobes are high for exactly one cycle before `req_ready` returns. `sram_dq_oe` is never 1 in a cycle where `sram_oe_n` is low, nor in the cycle after one.
- R10: The busy time is SETUP_CYC+LEAD_CYC+PULSE_CYC+HOLD_CYC+RECOV_CYC cycles for a write and SETUP_CYC+ACCESS_CYC+1 cycles for a read.
- R11: Changes on `req_valid`, `req_write`, `req_addr` and `req_wdata` while `req_ready` is 0 have no effect: no extra cycle, done pulse, address change or memory write results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last read result |
| sram_addr | output | ADDR_W | RAM address bus |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W | Data the controller drives onto the shared bus |
| sram_dq_oe | output | 1 | Enable of the controller's bus driver |
| sram_dq_in | input | DATA_W | Data sensed from the shared bus |

## Verification
The assertions check the relations between strobes on every cycle:
- the idle deselect;
- write enable leading chip select;
- output enable held high while write enable is low;
- data driven during every write overlap;
- no driver enable in or just after an output-enable-low cycle;
- an unchanged address while busy;
- a done pulse only with ready.

Phase lengths, the write hold, recovery and turnaround counts, the stored and read-back bytes, and the rejection of requests made while busy can only be shown by the bench. It runs address sweeps against a behavioural RAM model and times each phase of every request.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_LEAD,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WR_REC,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_TURN
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Pin levels seen by the RAM in each state.
    function automatic strobe_t strobes_for(input ctl_state_e s);
        strobe_t v;
        v = STROBE_IDLE;
        unique case (s)
            ST_IDLE:      v = STROBE_IDLE;
            ST_WR_SETUP:  v = STROBE_IDLE;
            ST_WR_LEAD:   v = '{cs_n: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_PULSE:  v = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_HOLD:   v = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_REC:    v = STROBE_IDLE;
            ST_RD_SETUP:  v = STROBE_IDLE;
            ST_RD_ACCESS: v = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_RD_TURN:   v = STROBE_IDLE;
            default:      v = STROBE_IDLE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int LEAD_CYC   = 1,
    parameter int PULSE_CYC  = 3,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 1,
    parameter int ACCESS_CYC = 3,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_write,
    input  logic             phase_over,
    output ctl_state_e       state_q,
    output ctl_state_e       state_d,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val
);

    // Cycle count of each phase, minus one, as loaded into the timer.
    function automatic logic [CNT_W-1:0] span(input ctl_state_e s);
        logic [CNT_W-1:0] n;
        n = '0;
        unique case (s)
            ST_IDLE:      n = '0;
            ST_WR_SETUP:  n = CNT_W'(SETUP_CYC - 1);
            ST_WR_LEAD:   n = CNT_W'(LEAD_CYC - 1);
            ST_WR_PULSE:  n = CNT_W'(PULSE_CYC - 1);
            ST_WR_HOLD:   n = CNT_W'((HOLD_CYC > 0) ? HOLD_CYC - 1 : 0);
            ST_WR_REC:    n = CNT_W'(RECOV_CYC - 1);
            ST_RD_SETUP:  n = CNT_W'(SETUP_CYC - 1);
            ST_RD_ACCESS: n = CNT_W'(ACCESS_CYC - 1);
            ST_RD_TURN:   n = '0;
            default:      n = '0;
        endcase
        return n;
    endfunction

    localparam ctl_state_e AFTER_PULSE = (HOLD_CYC == 0) ? ST_WR_REC : ST_WR_HOLD;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = is_write ? ST_WR_SETUP : ST_RD_SETUP;
            ST_WR_SETUP:  if (phase_over) state_d = ST_WR_LEAD;
            ST_WR_LEAD:   if (phase_over) state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (phase_over) state_d = AFTER_PULSE;
            ST_WR_HOLD:   if (phase_over) state_d = ST_WR_REC;
            ST_WR_REC:    if (phase_over) state_d = ST_IDLE;
            ST_RD_SETUP:  if (phase_over) state_d = ST_RD_ACCESS;
            ST_RD_ACCESS: if (phase_over) state_d = ST_RD_TURN;
            ST_RD_TURN:   if (phase_over) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign timer_load = (state_d != state_q);
    assign timer_val  = span(state_d);

    // A phase never ends before its timer runs out.
    AST_PHASE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !phase_over) |=> (state_q == $past(state_q))); // R10

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  ctl_state_e        state_q,
    input  ctl_state_e        state_d,
    input  logic              phase_over,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);

    strobe_t           strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    // Strobes come from the next state, so every pin leaves a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= STROBE_IDLE;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            strobe_q <= strobes_for(state_d);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_RD_ACCESS && phase_over) begin
                rdata_q <= sram_dq_in;
            end
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    assign sram_addr   = addr_q;
    assign sram_cs_n   = strobe_q.cs_n;
    assign sram_we_n   = strobe_q.we_n;
    assign sram_oe_n   = strobe_q.oe_n;
    assign sram_dq_oe  = strobe_q.dq_oe;
    assign sram_dq_out = wdata_q;
    assign rsp_rdata   = rdata_q;
    assign rsp_done    = done_q;

    AST_WE_LEADS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sram_cs_n) && !sram_we_n) |-> $past(!sram_we_n)); // R3

    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n); // R3

    AST_DATA_IN_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && !sram_we_n) |-> sram_dq_oe); // R6

    AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_cs_n)); // R8

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R2

endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int LEAD_CYC   = 1,
    parameter int PULSE_CYC  = 3,
    parameter int HOLD_CYC   = 1,
    parameter int RECOV_CYC  = 1,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int M1    = (SETUP_CYC > LEAD_CYC) ? SETUP_CYC : LEAD_CYC;
    localparam int M2    = (PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC;
    localparam int M3    = (RECOV_CYC > ACCESS_CYC) ? RECOV_CYC : ACCESS_CYC;
    localparam int M12   = (M1 > M2) ? M1 : M2;
    localparam int MAX_L = (M12 > M3) ? M12 : M3;
    localparam int CNT_W = $clog2(MAX_L + 1);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             phase_over;
    logic             accept;

    initial begin
        assert (SETUP_CYC >= 1 && LEAD_CYC >= 1 && PULSE_CYC >= 1 &&
                RECOV_CYC >= 1 && ACCESS_CYC >= 1 && HOLD_CYC >= 0)
            else $error("phase lengths out of range");
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_ctl_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .LEAD_CYC  (LEAD_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .RECOV_CYC (RECOV_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .CNT_W     (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .is_write  (req_write),
        .phase_over(phase_over),
        .state_q   (state_q),
        .state_d   (state_d),
        .timer_load(timer_load),
        .timer_val (timer_val)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(timer_val),
        .expired (phase_over)
    );

    sram_ctl_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) dp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .state_q    (state_q),
        .state_d    (state_d),
        .phase_over (phase_over),
        .sram_dq_in (sram_dq_in),
        .sram_addr  (sram_addr),
        .sram_cs_n  (sram_cs_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_dq_out(sram_dq_out),
        .sram_dq_oe (sram_dq_oe),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done)
    );

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(sram_addr)); // R4

endmodule

// File: tb/sram_cycle_ctl_tb_top.sv
module sram_cycle_ctl_tb_top;

    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int TS  = 2;
    localparam int TL  = 1;
    localparam int TP  = 3;
    localparam int TH  = 1;
    localparam int TR  = 2;
    localparam int TA  = 3;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in;

    always #10 clk = ~clk;

    sram_cycle_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(TS), .LEAD_CYC(TL),
        .PULSE_CYC(TP), .HOLD_CYC(TH), .RECOV_CYC(TR), .ACCESS_CYC(TA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Behavioural RAM: writes land when the overlap of both strobes ends.
    logic [DW-1:0] mem [NWORDS];
    logic [DW-1:0] shadow [NWORDS];
    logic          mem_drive;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;
    logic          prev_drive = 1'b0;

    assign mem_drive  = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq_in = mem_drive ? mem[sram_addr] : '0;

    int vectors = 0;
    int fails = 0;
    int fight_err = 0;
    int nodata_err = 0;
    int done_total = 0;
    int requests = 0;

    // Per-request measurements.
    int busy_c, setup_c, lead_c, pulse_c, hold_c, recov_c, oe_c;
    int addr_err, data_err, oe_in_wr;
    logic seen_strobe;
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_data;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_done) done_total++;
            if (sram_dq_oe && (mem_drive || prev_drive)) fight_err++;
            prev_drive = mem_drive;
            if (!sram_cs_n && !sram_we_n) begin
                if (!sram_dq_oe) nodata_err++;
                pend   = 1'b1;
                pend_a = sram_addr;
                pend_d = sram_dq_out;
            end else if (pend) begin
                mem[pend_a] = pend_d;
                pend = 1'b0;
            end
            if (!req_ready) begin
                busy_c++;
                if (sram_addr != exp_addr) addr_err++;
                if (sram_dq_oe && sram_dq_out != exp_data) data_err++;
                if (!sram_we_n && !sram_oe_n) oe_in_wr++;
                if (!sram_cs_n || !sram_we_n || !sram_oe_n) seen_strobe = 1'b1;
                if (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe) begin
                    if (seen_strobe) recov_c++;
                    else setup_c++;
                end
                if (!sram_we_n && sram_cs_n) lead_c++;
                if (!sram_we_n && !sram_cs_n) pulse_c++;
                if (sram_dq_oe && sram_we_n && sram_cs_n) hold_c++;
                if (!sram_oe_n) oe_c++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request at a negedge with ready high; wait for done.
    task automatic run_req(input logic wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic noisy);
        int guard;
        busy_c = 0; setup_c = 0; lead_c = 0; pulse_c = 0; hold_c = 0;
        recov_c = 0; oe_c = 0; addr_err = 0; data_err = 0; oe_in_wr = 0;
        seen_strobe = 1'b0;
        exp_addr  = a;
        exp_data  = d;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        requests++;
        guard = 0;
        @(negedge clk);
        check("R2 ready drops after accept", int'(req_ready), 0);
        req_valid = noisy;
        while (!rsp_done && guard < 100) begin
            if (noisy) begin
                req_write = ~req_write;
                req_addr  = req_addr + 7;
                req_wdata = req_wdata ^ 8'h5A;
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        check("R2 done pulse seen", int'(rsp_done), 1);
        check("R2 ready with done", int'(req_ready), 1);
        check("R4 setup cycles", setup_c, TS);
        check("R4 R11 address held", addr_err, 0);
        if (wr) begin
            check("R10 write busy", busy_c, TS + TL + TP + TH + TR);
            check("R3 we lead", lead_c, TL);
            check("R3 oe high in write", oe_c + oe_in_wr, 0);
            check("R5 pulse width", pulse_c, TP);
            check("R6 data hold", hold_c, TH);
            check("R6 data value", data_err, 0);
            check("R7 recovery", recov_c, TR);
        end else begin
            check("R10 read busy", busy_c, TS + TA + 1);
            check("R8 access width", oe_c, TA);
            check("R8 no write strobe", pulse_c + lead_c, 0);
            check("R9 turnaround", recov_c, 1);
            check("R8 read data", int'(rsp_rdata), int'(shadow[a]));
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic noisy);
        run_req(1'b1, a, d, noisy);
        shadow[a] = d;
        @(negedge clk);
        check("R6 stored byte", int'(mem[a]), int'(d));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NWORDS; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n idle", int'(sram_cs_n), 1);
        check("R1 we_n idle", int'(sram_we_n), 1);
        check("R1 oe_n idle", int'(sram_oe_n), 1);
        check("R1 dq_oe idle", int'(sram_dq_oe), 0);
        check("R1 ready idle", int'(req_ready), 1);
        check("R1 no done", int'(rsp_done), 0);

        // Fill every address; some requests with busy-time noise (R11).
        for (int a = 0; a < NWORDS; a++)
            do_write(AW'(a), DW'((a * 37 + 5) & 8'hFF), (a % 5) == 0);
        for (int a = 0; a < NWORDS; a++)
            run_req(1'b0, AW'(a), '0, (a % 4) == 1);
        // Overwrite every third word with the complement.
        for (int a = 0; a < NWORDS; a += 3)
            do_write(AW'(a), ~DW'((a * 37 + 5) & 8'hFF), 1'b0);
        // Back-to-back read then write: bus turnaround.
        for (int a = 0; a < NWORDS; a++) begin
            run_req(1'b0, AW'(a), '0, 1'b0);
            do_write(AW'(a ^ (NWORDS - 1)), DW'(a ^ 8'hC3), 1'b0);
        end
        for (int a = 0; a < NWORDS; a++)
            run_req(1'b0, AW'(a), '0, 1'b0);

        repeat (3) @(negedge clk);
        check("R1 idle deselect at end", int'(sram_cs_n & sram_we_n & sram_oe_n), 1);
        check("R2 R11 one done per request", done_total, requests);
        check("R9 no bus fight", fight_err, 0);
        check("R6 data driven in overlap", nodata_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule